// File: doc/BRIEF.md
# NAND Bus Cycle Decoder

This block sits between a processor's memory-mapped bank window and the pins of an external NAND flash. Each access that arrives on the bank request stream becomes one NAND bus cycle: a command-latch cycle, an address-latch cycle or a plain data cycle. Two address bits of the access pick which one. A write drives the byte onto the data bus under a write-enable strobe. A read pulses read-enable, samples the data bus and returns the byte on a response stream.

The bank request stream is valid/ready. A request is taken on a clock edge where `bank_valid` and `bank_ready` are both high. `bank_ready` is high only while no bus cycle or read response is pending, so one request is served at a time. The read response stream is also valid/ready. `rd_valid` stays high, with `rd_data` unchanged, until the consumer raises `rd_ready`.

A small register port holds three words:
- Control, at offset 0x50: chip-select enable and assert bits for up to four chips.
- Status, at offset 0x54: the synchronised ready/busy pin and a sticky error flag for rejected accesses.
- Strobe width, at offset 0x58.

Top module: `nand_cycle_decoder`

## Requirements
- R1: A bank access with address bit 15 set and bit 16 clear is a command cycle. `nand_cle` is high and `nand_ale` is low from the setup cycle through the hold cycle.
- R2: A bank access with bit 16 set and bit 15 clear is an address cycle. `nand_ale` is high and `nand_cle` is low for the whole cycle.
- R3: A bank access with bits 15 and 16 both clear is a data cycle, with `nand_cle` and `nand_ale` both low.
- R4: An access with bits 15 and 16 both set is rejected:
  - No strobe is pulsed.
  - Status bit 1 (error) becomes 1.
  - A rejected read still returns a response with data 0x00.
  - Writing status (0x54) with bit 1 set clears the flag.
  - CLE and ALE are never high together.
- R5: Control register (0x50): bit 2n enables chip n and bit 2n+1 asserts chip n. `nand_ce_n[n]` is low only when both bits are 1.
- R6: Writing zero to the control register drives every `nand_ce_n` bit high from the next cycle on.
- R7: A write cycle has three phases. The data bus is driven (`nand_dq_oe`=1, `nand_dq_o`=the write byte) throughout.
  - One setup cycle with `nand_we_n` high.
  - `nand_we_n` low for W cycles.
  - One hold cycle.

  W is bits 3:0 of the width register (0x58). W resets to 4, and a written value of 0 is stored as 1.
- R8: A read cycle has the same setup, W-cycle `nand_re_n` low and hold phases. The data bus is not driven. `nand_dq_i` is sampled on the edge that ends the strobe and returned on `rd_data`.
- R9: While a cycle or response is pending, `bank_ready` is low and no second request is taken. A pending response keeps `rd_valid` high and `rd_data` stable until `rd_ready` is high.
- R10: Status bit 0 equals `nand_rb` as it was two clock edges earlier. This bit is 0 in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_valid | input | 1 | Bank request valid |
| bank_ready | output | 1 | Bank request accepted when high with valid |
| bank_write | input | 1 | 1 = write, 0 = read |
| bank_addr | input | 17 | Offset within the bank window (bits 16/15 select the latch mode) |
| bank_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | Read response valid |
| rd_ready | input | 1 | Read response consumed when high with valid |
| rd_data | output | 8 | Read response byte |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_ce_n | output | 4 | Active-low chip enables |
| nand_we_n | output | 1 | Active-low write strobe |
| nand_re_n | output | 1 | Active-low read strobe |
| nand_dq_o | output | 8 | Data bus out |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | 8 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin (1 = ready) |

## Verification
The assertions check the following on every cycle:
- CLE and ALE are never high together.
- The two strobes are never low at the same time.
- The data bus is driven and steady whenever write-enable is low.
- No strobe is active while a request can be accepted.
- A stalled read response holds its value.
- A rejected access sets the error flag.
- Clearing the control word releases all chip enables.

Only the bench scenarios can show the rest:
- The latch mode chosen for each offset.
- The exact strobe width for several programmed widths, including the zero-clamp.
- The setup and hold cycles.
- The byte sampled on reads.
- The absence of any strobe for a rejected access.
- The per-chip enable/assert combinations.
- The two-edge delay of the ready/busy mirror.

// File: rtl/nand_dec_pkg.sv
package nand_dec_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_STROBE,
    S_HOLD,
    S_RESP
  } seq_state_e;

  // bank offset bits that select the latch mode
  localparam int CMD_BIT  = 15;
  localparam int ADDR_BIT = 16;

  // register offsets
  localparam logic [8:0] OFS_CTRL  = 9'h050;
  localparam logic [8:0] OFS_STAT  = 9'h054;
  localparam logic [8:0] OFS_WIDTH = 9'h058;

  localparam int STAT_RB_BIT  = 0;
  localparam int STAT_ERR_BIT = 1;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], async_i};
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/nand_ctrl_regs.sv
module nand_ctrl_regs
  import nand_dec_pkg::*;
#(
  parameter int NCHIP     = 4,
  parameter int CW        = 4,
  parameter int WIDTH_RST = 4,
  parameter int RAW       = 9,
  parameter int RDW       = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_i,
  input  logic [RAW-1:0]     addr_i,
  input  logic [RDW-1:0]     wdata_i,
  input  logic               reject_i,
  input  logic               rb_sync_i,
  output logic [2*NCHIP-1:0] ctrl_o,
  output logic [CW-1:0]      width_o,
  output logic [RDW-1:0]     rdata_o
);
  localparam int CTRL_W = 2 * NCHIP;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CW-1:0]     width_q;
  logic              err_q;
  logic              wr_ctrl, wr_stat, wr_width;

  assign wr_ctrl  = wr_i && (addr_i == OFS_CTRL);
  assign wr_stat  = wr_i && (addr_i == OFS_STAT);
  assign wr_width = wr_i && (addr_i == OFS_WIDTH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      width_q <= CW'(WIDTH_RST);
      err_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdata_i[CTRL_W-1:0];
      if (wr_width) begin
        if (wdata_i[CW-1:0] == '0) width_q <= CW'(1);
        else                       width_q <= wdata_i[CW-1:0];
      end
      if (reject_i)                        err_q <= 1'b1;
      else if (wr_stat && wdata_i[STAT_ERR_BIT]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_CTRL:  rdata_o[CTRL_W-1:0] = ctrl_q;
      OFS_STAT: begin
        rdata_o[STAT_RB_BIT]  = rb_sync_i;
        rdata_o[STAT_ERR_BIT] = err_q;
      end
      OFS_WIDTH: rdata_o[CW-1:0] = width_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o  = ctrl_q;
  assign width_o = width_q;

  // R4: a rejected access leaves the error flag set
  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reject_i |=> err_q);

  // R7: the stored width is never zero
  assert_width_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_width |=> (width_q != '0));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_dec_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bank_valid_i,
  output logic          bank_ready_o,
  input  logic          bank_write_i,
  input  logic [AW-1:0] bank_addr_i,
  input  logic [DW-1:0] bank_wdata_i,
  input  logic [CW-1:0] width_i,
  output logic          rd_valid_o,
  input  logic          rd_ready_i,
  output logic [DW-1:0] rd_data_o,
  output logic          cle_o,
  output logic          ale_o,
  output logic          we_n_o,
  output logic          re_n_o,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic [DW-1:0] dq_i,
  output logic          reject_o
);
  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          cle_q, ale_q, rd_q;
  logic [DW-1:0] dq_q, rdata_q;
  logic          accept, both_sel, active;

  assign bank_ready_o = (state_q == S_IDLE);
  assign accept       = bank_valid_i && bank_ready_o;
  assign both_sel     = bank_addr_i[CMD_BIT] && bank_addr_i[ADDR_BIT];
  assign reject_o     = accept && both_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      cle_q   <= 1'b0;
      ale_q   <= 1'b0;
      rd_q    <= 1'b0;
      dq_q    <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            if (both_sel) begin
              if (!bank_write_i) begin
                rdata_q <= '0;
                state_q <= S_RESP;
              end
            end else begin
              cle_q   <= bank_addr_i[CMD_BIT];
              ale_q   <= bank_addr_i[ADDR_BIT];
              rd_q    <= !bank_write_i;
              dq_q    <= bank_wdata_i;
              cnt_q   <= width_i;
              state_q <= S_SETUP;
            end
          end
        end
        S_SETUP: state_q <= S_STROBE;
        S_STROBE: begin
          if (cnt_q <= CW'(1)) begin
            if (rd_q) rdata_q <= dq_i;
            state_q <= S_HOLD;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        S_HOLD: state_q <= rd_q ? S_RESP : S_IDLE;
        S_RESP: if (rd_ready_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign active     = (state_q == S_SETUP) || (state_q == S_STROBE) || (state_q == S_HOLD);
  assign cle_o      = active && cle_q;
  assign ale_o      = active && ale_q;
  assign we_n_o     = !((state_q == S_STROBE) && !rd_q);
  assign re_n_o     = !((state_q == S_STROBE) && rd_q);
  assign dq_oe_o    = active && !rd_q;
  assign dq_o       = dq_q;
  assign rd_valid_o = (state_q == S_RESP);
  assign rd_data_o  = rdata_q;

  // R4: latch enables are mutually exclusive
  assert_cle_ale_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle_o && ale_o));

  // R8: never both strobes low
  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));

  // R7: bus driven and steady while write strobe is low
  assert_dq_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> dq_oe_o && $stable(dq_o));

  // R9: no strobe while a request may be accepted
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ready_o |-> we_n_o && re_n_o && !dq_oe_o);

  // R9: stalled response holds
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o));
endmodule

// File: rtl/nand_cycle_decoder.sv
module nand_cycle_decoder
  import nand_dec_pkg::*;
#(
  parameter int NCHIP     = 4,
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CW        = 4,
  parameter int WIDTH_RST = 4,
  parameter int RAW       = 9,
  parameter int RDW       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bank_valid,
  output logic             bank_ready,
  input  logic             bank_write,
  input  logic [AW-1:0]    bank_addr,
  input  logic [DW-1:0]    bank_wdata,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  input  logic             reg_wr,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [RDW-1:0]   reg_wdata,
  output logic [RDW-1:0]   reg_rdata,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic [NCHIP-1:0] nand_ce_n,
  output logic             nand_we_n,
  output logic             nand_re_n,
  output logic [DW-1:0]    nand_dq_o,
  output logic             nand_dq_oe,
  input  logic [DW-1:0]    nand_dq_i,
  input  logic             nand_rb
);
  logic [2*NCHIP-1:0] ctrl;
  logic [CW-1:0]      width;
  logic               reject;
  logic               rb_sync;

  nand_rb_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(nand_rb), .sync_o(rb_sync)
  );

  nand_ctrl_regs #(
    .NCHIP(NCHIP), .CW(CW), .WIDTH_RST(WIDTH_RST), .RAW(RAW), .RDW(RDW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .reject_i(reject), .rb_sync_i(rb_sync),
    .ctrl_o(ctrl), .width_o(width), .rdata_o(reg_rdata)
  );

  nand_cycle_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .bank_valid_i(bank_valid), .bank_ready_o(bank_ready),
    .bank_write_i(bank_write), .bank_addr_i(bank_addr),
    .bank_wdata_i(bank_wdata), .width_i(width),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .cle_o(nand_cle), .ale_o(nand_ale), .we_n_o(nand_we_n),
    .re_n_o(nand_re_n), .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe),
    .dq_i(nand_dq_i), .reject_o(reject)
  );

  for (genvar n = 0; n < NCHIP; n++) begin : g_ce
    assign nand_ce_n[n] = !(ctrl[2*n] && ctrl[2*n+1]);
  end

  // R6: clearing the control word releases every chip
  assert_ce_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == OFS_CTRL) && (reg_wdata == '0) |=> (&nand_ce_n));
endmodule

// File: tb/test_nand_cycle_decoder.sv
module test_nand_cycle_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bank_valid = 0, bank_write = 0;
  logic [16:0] bank_addr = '0;
  logic [7:0]  bank_wdata = '0;
  logic        bank_ready, rd_valid;
  logic        rd_ready = 0;
  logic [7:0]  rd_data;
  logic        reg_wr = 0;
  logic [8:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [3:0]  nand_ce_n;
  logic [7:0]  nand_dq_o;
  logic [7:0]  nand_dq_i = '0;
  logic        nand_rb = 1;

  always #2 clk = ~clk;

  nand_cycle_decoder i_nand_cycle_decoder (
    .clk(clk), .rst_n(rst_n), .bank_valid(bank_valid), .bank_ready(bank_ready),
    .bank_write(bank_write), .bank_addr(bank_addr), .bank_wdata(bank_wdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
    .nand_rb(nand_rb)
  );

  typedef struct {
    bit       is_rd;
    bit       cle;
    bit       ale;
    bit [7:0] data;
    int       width;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0, strobes = 0;
  int cur_width = 4;
  bit done = 0;

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  // monitor: observes each strobe on the pins and compares to the queue
  bit prev_low = 0, prev_cle = 0, prev_ale = 0;
  int low_cnt = 0;
  bit c_rd, c_cle, c_ale, c_oe, s_cle, s_ale;
  logic [7:0] c_dq;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_we_n || !nand_re_n) begin
        if (!prev_low) begin
          low_cnt = 1;
          c_rd = !nand_re_n; c_cle = nand_cle; c_ale = nand_ale;
          c_dq = nand_dq_o; c_oe = nand_dq_oe;
          s_cle = prev_cle; s_ale = prev_ale;
        end else begin
          low_cnt++;
          if (!nand_we_n) chk(nand_dq_o == c_dq && nand_dq_oe, "R7 dq steady", nand_dq_o, c_dq);
        end
        prev_low = 1;
      end else begin
        if (prev_low) begin
          strobes++;
          if (exp_q.size() == 0) chk(0, "R4 unexpected strobe", 1, 0);
          else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(c_rd == e.is_rd, "R8 strobe kind", c_rd, e.is_rd);
            chk(c_cle == e.cle && s_cle == e.cle && nand_cle == e.cle, "R1 cle setup/strobe/hold", {s_cle, c_cle, nand_cle}, {3{e.cle}});
            chk(c_ale == e.ale && s_ale == e.ale && nand_ale == e.ale, "R2 ale setup/strobe/hold", {s_ale, c_ale, nand_ale}, {3{e.ale}});
            chk(low_cnt == e.width, "R7 strobe width", low_cnt, e.width);
            if (!e.is_rd)
              chk(c_dq == e.data && c_oe && nand_dq_oe && nand_dq_o == e.data, "R7 write data", c_dq, e.data);
            else
              chk(!c_oe, "R8 bus released on read", c_oe, 0);
          end
        end
        prev_low = 0;
      end
      prev_cle = nand_cle;
      prev_ale = nand_ale;
    end
  end

  task automatic reg_write(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [8:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (!bank_ready || !nand_we_n || !nand_re_n) @(negedge clk);
    @(negedge clk);
  endtask

  // driver: pushes the expectation then issues the request
  task automatic bank_op(bit wr, logic [16:0] a, logic [7:0] d, bit expect_cycle);
    if (expect_cycle) begin
      exp_t e;
      e.is_rd = !wr; e.cle = a[15]; e.ale = a[16]; e.data = d; e.width = cur_width;
      exp_q.push_back(e);
    end
    @(negedge clk);
    bank_valid = 1; bank_write = wr; bank_addr = a; bank_wdata = d;
    while (!bank_ready) @(negedge clk);
    @(negedge clk);
    bank_valid = 0;
    if (expect_cycle || !wr)
      chk(!bank_ready, "R9 back-pressure while busy", bank_ready, 0);
  endtask

  task automatic bank_read(logic [16:0] a, bit expect_cycle, logic [7:0] expd);
    logic [7:0] first;
    bank_op(0, a, 8'h00, expect_cycle);
    while (!rd_valid) @(negedge clk);
    first = rd_data;
    repeat (2) @(negedge clk);
    chk(rd_valid && rd_data == first, "R9 response held", rd_data, first);
    chk(rd_data == expd, "R8 read data", rd_data, expd);
    rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
    chk(!rd_valid, "R9 response retired", rd_valid, 0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    int sc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    chk(nand_ce_n == 4'hF && nand_we_n && nand_re_n && !nand_cle && !nand_ale && bank_ready && !rd_valid,
        "R5 reset pins", {nand_ce_n, nand_we_n, nand_re_n}, 6'h3F);
    reg_read(9'h058, r);
    chk(r == 4, "R7 reset width", r, 4);
    repeat (3) @(negedge clk);
    reg_read(9'h054, r);
    chk(r == 1, "R10 ready mirrored", r, 1);

    // latch modes
    bank_op(1, 17'h08000, 8'h70, 1); wait_idle();   // R1
    bank_op(1, 17'h10000, 8'h12, 1); wait_idle();   // R2
    bank_op(1, 17'h00000, 8'hA5, 1); wait_idle();   // R3
    bank_op(1, 17'h00123, 8'h5A, 1); wait_idle();   // R3 other low bits
    nand_dq_i = 8'h3C;
    bank_read(17'h00000, 1, 8'h3C); wait_idle();    // R8
    nand_dq_i = 8'hC7;
    bank_read(17'h10004, 1, 8'hC7); wait_idle();    // R8 with ALE

    // strobe widths R7
    reg_write(9'h058, 2); cur_width = 2;
    bank_op(1, 17'h08000, 8'h90, 1); wait_idle();
    reg_write(9'h058, 0); cur_width = 1;
    reg_read(9'h058, r);
    chk(r == 1, "R7 zero width stored as one", r, 1);
    bank_op(1, 17'h00000, 8'h01, 1); wait_idle();
    nand_dq_i = 8'h81;
    bank_read(17'h00000, 1, 8'h81); wait_idle();
    reg_write(9'h058, 7); cur_width = 7;
    bank_op(1, 17'h10000, 8'hFE, 1); wait_idle();

    // rejected accesses R4
    sc = strobes;
    bank_op(1, 17'h18000, 8'h33, 0);
    repeat (12) @(negedge clk);
    chk(strobes == sc && nand_we_n && nand_re_n, "R4 no strobe on reject", strobes - sc, 0);
    reg_read(9'h054, r);
    chk(r[1] == 1, "R4 error flag set", r[1], 1);
    reg_write(9'h054, 32'h2);
    reg_read(9'h054, r);
    chk(r[1] == 0, "R4 error flag cleared", r[1], 0);
    bank_read(17'h18000, 0, 8'h00);
    repeat (12) @(negedge clk);
    chk(strobes == sc, "R4 no strobe on rejected read", strobes - sc, 0);
    reg_read(9'h054, r);
    chk(r[1] == 1, "R4 error flag on read reject", r[1], 1);
    reg_write(9'h054, 32'h2);

    // chip selects R5 / R6
    reg_write(9'h050, 32'h01);
    chk(nand_ce_n == 4'hF, "R5 enable alone", nand_ce_n, 4'hF);
    reg_write(9'h050, 32'h02);
    chk(nand_ce_n == 4'hF, "R5 assert alone", nand_ce_n, 4'hF);
    reg_write(9'h050, 32'h03);
    chk(nand_ce_n == 4'hE, "R5 chip0", nand_ce_n, 4'hE);
    reg_write(9'h050, 32'hC3);
    chk(nand_ce_n == 4'h6, "R5 chips 0 and 3", nand_ce_n, 4'h6);
    reg_write(9'h050, 32'h5C);
    chk(nand_ce_n == 4'hD, "R5 chip1 only", nand_ce_n, 4'hD);
    reg_write(9'h050, 32'hFF);
    chk(nand_ce_n == 4'h0, "R5 all chips", nand_ce_n, 4'h0);
    reg_write(9'h050, 32'h00);
    chk(nand_ce_n == 4'hF, "R6 zero releases all", nand_ce_n, 4'hF);

    // ready/busy mirror R10
    @(negedge clk); nand_rb = 0;
    @(negedge clk); reg_read(9'h054, r);
    chk(r[0] == 1, "R10 one edge: old value", r[0], 1);
    @(negedge clk); reg_read(9'h054, r);
    chk(r[0] == 0, "R10 two edges: new value", r[0], 0);
    nand_rb = 1;
    repeat (2) @(negedge clk); reg_read(9'h054, r);
    chk(r[0] == 1, "R10 back to ready", r[0], 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all strobes observed", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule